// File: doc/BRIEF.md
# Asynchronous Read Strobe Sequencer

This block runs one asynchronous single read on an external parallel memory. When a request is accepted, a cycle counter starts at zero. The chip-select, address-valid and output-enable strobes each switch at their own programmed counts. The read data on the bus is captured at a separate programmed capture count. The access lasts for a programmed total number of cycles. A multiplexed mode puts the low address bits on the shared bus until output enable asserts, and then hands the bus to the memory. When the block is not reading, it drives the last captured word back onto the bus, so that the bus is never left floating.

Before an access starts, the timing values are checked. A set of values that cannot work raises a one-cycle error pulse, and no access is started. A limited-address option freezes the upper address pins and reloads only the low bits on each access. The block has two states. ST_IDLE waits for a request. ST_RUN counts through the access. There are two transitions. The start transition (ST_IDLE to ST_RUN) is taken when a request arrives with valid timing. The finish transition (ST_RUN to ST_IDLE) is taken on the last count of the access.

Top module: `xmem_rd_sequencer`

## Requirements
- R1: After reset, cs_n, adv_n and oe_n are 1, bus_oe is 1, dir_in is 0, req_ready is 1, and rd_data, bus_out, addr_out, rd_done and cfg_err are all 0.
- R2: A request (req_valid=1 while req_ready=1) with valid timing starts an access. The cycle after the accepting edge has count 0. An access of length t_cycle occupies counts 0 to t_cycle-1, and req_ready is 0 for exactly those cycles.
- R3: cs_n is 0 exactly in the cycles whose count k satisfies t_cs_on <= k < t_cs_off, and is 1 at all other times.
- R4: adv_n is 0 exactly in the cycles whose count k satisfies t_adv_on <= k < t_adv_off.
- R5: oe_n is 0 exactly in the cycles whose count k satisfies t_oe_on <= k < t_oe_off.
- R6: bus_in is captured on the clock edge that ends count t_capture-1. rd_data shows the captured value from count t_capture onward, and keeps it until the next capture.
- R7: rd_done is 1 for exactly one cycle, the cycle after the last count of an access.
- R8: dir_in is 1 and bus_oe is 0 from count t_oe_on until the end of the access. In that count, oe_n falls in the same cycle. At all other times, dir_in is 0 and bus_oe is 1.
- R9: With mux_mode=1 latched at the start, bus_out carries addr_out[DATA_W-1:0] in the access counts below t_oe_on.
- R10: Whenever bus_oe is 1, bus_out equals rd_data, except in the multiplexed address phase of R9.
- R11: At the start of an access, addr_out[HOLD_LSB-1:0] loads from req_addr. The bits at HOLD_LSB and above load from req_addr only when addr_hold=0, and otherwise keep their previous value (default HOLD_LSB=8).
- R12: A request is rejected if any of the following holds: t_cycle=0; t_capture=0; t_capture > t_cycle; any off count > t_cycle; or any on count > its matching off count. A rejected request gives cfg_err=1 for the one following cycle, starts no access and leaves rd_data unchanged.
- R13: The timing inputs and mux_mode are sampled when the request is accepted. Changes to them during an access have no effect on that access.
- R14: With the timing cs 0/10, adv 0/1, oe 3/10, capture 9 and cycle 11, the access has this shape: cs_n low at counts 0 to 9, adv_n low at count 0, oe_n low at counts 3 to 9, capture at the edge ending count 8, and rd_done in the cycle after count 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | High while idle; the request is taken when both are high |
| t_cs_on | input | 4 | Chip-select assert count |
| t_cs_off | input | 5 | Chip-select release count |
| t_adv_on | input | 4 | Address-valid assert count |
| t_adv_off | input | 5 | Address-valid release count |
| t_oe_on | input | 4 | Output-enable assert count |
| t_oe_off | input | 5 | Output-enable release count |
| t_capture | input | 5 | Data capture count |
| t_cycle | input | 5 | Total access length in cycles |
| mux_mode | input | 1 | 1 = address and data share the bus |
| addr_hold | input | 1 | 1 = keep the upper address pins |
| bus_in | input | DATA_W | Data read from the bus |
| bus_out | output | DATA_W | Value driven onto the bus |
| bus_oe | output | 1 | 1 = block drives the bus |
| dir_in | output | 1 | Bus direction, 1 = toward the block |
| addr_out | output | ADDR_W | Address pins |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| rd_data | output | DATA_W | Captured read word |
| rd_done | output | 1 | One-cycle end-of-access pulse |
| cfg_err | output | 1 | One-cycle rejected-timing pulse |

## Verification
A counter that is off by one moves every strobe edge by one cycle in the very first access. The bench drives a different bus value in every count, so the same fault also shows as a wrong rd_data word in the first count after capture. A state register stuck in ST_RUN keeps req_ready low and never raises rd_done, which is seen one cycle after the expected last count. Timing values that are not latched, or a bad timing check, show up in the cycle right after the request: cfg_err is missing, or the strobes move when the inputs are changed during an access.

// File: rtl/xmem_rd_pkg.sv
package xmem_rd_pkg;

    // Field widths of the timing counts
    localparam int XR_ON_W  = 4;
    localparam int XR_OFF_W = 5;

    // Strobe indices
    localparam int XR_NSTROBE = 3;
    localparam int XR_STB_CS  = 0;
    localparam int XR_STB_ADV = 1;
    localparam int XR_STB_OE  = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xr_state_e;

    typedef struct packed {
        logic [XR_ON_W-1:0]  cs_on;
        logic [XR_OFF_W-1:0] cs_off;
        logic [XR_ON_W-1:0]  adv_on;
        logic [XR_OFF_W-1:0] adv_off;
        logic [XR_ON_W-1:0]  oe_on;
        logic [XR_OFF_W-1:0] oe_off;
        logic [XR_OFF_W-1:0] acc;
        logic [XR_OFF_W-1:0] cyc;
        logic                mux;
    } xr_timing_t;

endpackage

// File: rtl/xmem_rd_cfgchk.sv
module xmem_rd_cfgchk
    import xmem_rd_pkg::*;
(
    input  xr_timing_t tim,
    output logic       bad
);

    logic cyc_zero;
    logic acc_zero;
    logic acc_late;
    logic off_late;
    logic on_late;

    always_comb begin
        cyc_zero = (tim.cyc == '0);
        acc_zero = (tim.acc == '0);
        acc_late = (tim.acc > tim.cyc);
        off_late = (tim.cs_off > tim.cyc) || (tim.adv_off > tim.cyc) ||
                   (tim.oe_off > tim.cyc);
        on_late  = (XR_OFF_W'(tim.cs_on)  > tim.cs_off)  ||
                   (XR_OFF_W'(tim.adv_on) > tim.adv_off) ||
                   (XR_OFF_W'(tim.oe_on)  > tim.oe_off);
        bad      = cyc_zero || acc_zero || acc_late || off_late || on_late;
    end

endmodule

// File: rtl/xmem_rd_window.sv
module xmem_rd_window #(
    parameter int ON_W  = 4,
    parameter int OFF_W = 5
) (
    input  logic             active,
    input  logic [OFF_W-1:0] cnt,
    input  logic [ON_W-1:0]  t_on,
    input  logic [OFF_W-1:0] t_off,
    output logic             strobe_n
);

    logic past_on;
    logic before_off;

    always_comb begin
        past_on    = (cnt >= OFF_W'(t_on));
        before_off = (cnt < t_off);
        strobe_n   = !(active && past_on && before_off);
    end

endmodule

// File: rtl/xmem_rd_addrreg.sv
module xmem_rd_addrreg #(
    parameter int ADDR_W   = 24,
    parameter int HOLD_LSB = 8   // must be at least 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              hold,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    generate
        if (HOLD_LSB >= ADDR_W) begin : g_flat
            // No upper region: every bit reloads on each access
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q <= '0;
                end else if (load) begin
                    addr_q <= addr_in;
                end
            end
        end else begin : g_split
            localparam int UP_W = ADDR_W - HOLD_LSB;
            logic [HOLD_LSB-1:0] low_q;
            logic [UP_W-1:0]     up_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    low_q <= '0;
                    up_q  <= '0;
                end else if (load) begin
                    low_q <= addr_in[HOLD_LSB-1:0];
                    if (!hold) begin
                        up_q <= addr_in[ADDR_W-1:HOLD_LSB];
                    end
                end
            end

            assign addr_q = {up_q, low_q};
        end
    endgenerate

endmodule

// File: rtl/xmem_rd_sequencer.sv
module xmem_rd_sequencer
    import xmem_rd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int HOLD_LSB = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    input  logic [XR_ON_W-1:0]  t_cs_on,
    input  logic [XR_OFF_W-1:0] t_cs_off,
    input  logic [XR_ON_W-1:0]  t_adv_on,
    input  logic [XR_OFF_W-1:0] t_adv_off,
    input  logic [XR_ON_W-1:0]  t_oe_on,
    input  logic [XR_OFF_W-1:0] t_oe_off,
    input  logic [XR_OFF_W-1:0] t_capture,
    input  logic [XR_OFF_W-1:0] t_cycle,
    input  logic                mux_mode,
    input  logic                addr_hold,
    input  logic [DATA_W-1:0]   bus_in,
    output logic [DATA_W-1:0]   bus_out,
    output logic                bus_oe,
    output logic                dir_in,
    output logic [ADDR_W-1:0]   addr_out,
    output logic                cs_n,
    output logic                adv_n,
    output logic                oe_n,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_done,
    output logic                cfg_err
);

    localparam int CNT_W = XR_OFF_W;

    xr_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    xr_timing_t         tim_in, tim_q;
    logic [DATA_W-1:0]  data_q;
    logic               done_q;
    logic               err_q;
    logic               cfg_bad;
    logic               accept;
    logic               start;
    logic               running;
    logic               last_cnt;
    logic               capture_now;
    logic               turned_in;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  mux_addr;
    logic [XR_ON_W-1:0]  on_arr  [XR_NSTROBE];
    logic [XR_OFF_W-1:0] off_arr [XR_NSTROBE];
    logic [XR_NSTROBE-1:0] stb_n;

    // Gather the timing inputs into one record
    always_comb begin
        tim_in.cs_on   = t_cs_on;
        tim_in.cs_off  = t_cs_off;
        tim_in.adv_on  = t_adv_on;
        tim_in.adv_off = t_adv_off;
        tim_in.oe_on   = t_oe_on;
        tim_in.oe_off  = t_oe_off;
        tim_in.acc     = t_capture;
        tim_in.cyc     = t_cycle;
        tim_in.mux     = mux_mode;
    end

    xmem_rd_cfgchk u_cfgchk (
        .tim (tim_in),
        .bad (cfg_bad)
    );

    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign start       = accept && !cfg_bad;
    assign running     = (state_q == ST_RUN);
    assign last_cnt    = (cnt_q == (tim_q.cyc - CNT_W'(1)));
    assign capture_now = running && (cnt_q == (tim_q.acc - CNT_W'(1)));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: start (idle to run), finish (run to idle)
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_RUN: begin
                if (last_cnt) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        endcase
    end

    // Timing record, captured word and event pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q  <= '0;
            data_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start) begin
                tim_q <= tim_in;
            end
            if (capture_now) begin
                data_q <= bus_in;
            end
            done_q <= running && last_cnt;
            err_q  <= accept && cfg_bad;
        end
    end

    xmem_rd_addrreg #(
        .ADDR_W   (ADDR_W),
        .HOLD_LSB (HOLD_LSB)
    ) u_addrreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .hold    (addr_hold),
        .addr_in (req_addr),
        .addr_q  (addr_q)
    );

    // Per-strobe windows
    always_comb begin
        on_arr[XR_STB_CS]   = tim_q.cs_on;
        off_arr[XR_STB_CS]  = tim_q.cs_off;
        on_arr[XR_STB_ADV]  = tim_q.adv_on;
        off_arr[XR_STB_ADV] = tim_q.adv_off;
        on_arr[XR_STB_OE]   = tim_q.oe_on;
        off_arr[XR_STB_OE]  = tim_q.oe_off;
    end

    generate
        for (genvar s = 0; s < XR_NSTROBE; s++) begin : g_stb
            xmem_rd_window #(
                .ON_W  (XR_ON_W),
                .OFF_W (XR_OFF_W)
            ) u_win (
                .active   (running),
                .cnt      (cnt_q),
                .t_on     (on_arr[s]),
                .t_off    (off_arr[s]),
                .strobe_n (stb_n[s])
            );
        end
    endgenerate

    generate
        if (ADDR_W >= DATA_W) begin : g_mux_trim
            assign mux_addr = addr_q[DATA_W-1:0];
        end else begin : g_mux_pad
            assign mux_addr = {{(DATA_W - ADDR_W){1'b0}}, addr_q};
        end
    endgenerate

    // Outputs
    always_comb begin
        turned_in = running && (cnt_q >= CNT_W'(tim_q.oe_on));
        req_ready = (state_q == ST_IDLE);
        cs_n      = stb_n[XR_STB_CS];
        adv_n     = stb_n[XR_STB_ADV];
        oe_n      = stb_n[XR_STB_OE];
        dir_in    = turned_in;
        bus_oe    = !turned_in;
        bus_out   = (running && tim_q.mux && !turned_in) ? mux_addr : data_q;
        addr_out  = addr_q;
        rd_data   = data_q;
        rd_done   = done_q;
        cfg_err   = err_q;
    end

endmodule

// File: rtl/xmem_rd_sequencer_chk.sv
module xmem_rd_sequencer_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cs_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              dir_in,
    input logic              bus_oe,
    input logic              rd_done,
    input logic              cfg_err,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] addr_out
);

    // R3 R4 R5: no strobe is active while idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && adv_n && oe_n && bus_oe));

    // R7: done is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R2: the access is over when done shows
    p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> req_ready);

    // R8: bus turns around in the cycle output enable falls
    p_dir_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> (dir_in && !bus_oe));

    // R12: a rejected request starts nothing
    p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (req_ready && cs_n && !rd_done));

    // R6: the captured word holds while idle
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready)) |-> $stable(rd_data));

    // R13: the address pins do not move within an access
    p_addr_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(addr_out));

endmodule

bind xmem_rd_sequencer xmem_rd_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/xmem_rd_sequencer_tb.sv
module xmem_rd_sequencer_tb;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int HOLD   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic [3:0]        t_cs_on = '0, t_adv_on = '0, t_oe_on = '0;
    logic [4:0]        t_cs_off = '0, t_adv_off = '0, t_oe_off = '0;
    logic [4:0]        t_capture = '0, t_cycle = '0;
    logic              mux_mode = 1'b0, addr_hold = 1'b0;
    logic [DATA_W-1:0] bus_in = '0;
    logic [DATA_W-1:0] bus_out, rd_data;
    logic              bus_oe, dir_in, cs_n, adv_n, oe_n, rd_done, cfg_err;
    logic [ADDR_W-1:0] addr_out;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    logic [ADDR_W-1:0] addr_m = '0;
    logic [DATA_W-1:0] data_m = '0;

    always #(CLK_P/2) clk = ~clk;

    xmem_rd_sequencer #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .HOLD_LSB (HOLD)
    ) u_dut (
        .clk, .rst_n, .req_valid, .req_addr, .req_ready,
        .t_cs_on, .t_cs_off, .t_adv_on, .t_adv_off, .t_oe_on, .t_oe_off,
        .t_capture, .t_cycle, .mux_mode, .addr_hold, .bus_in,
        .bus_out, .bus_oe, .dir_in, .addr_out, .cs_n, .adv_n, .oe_n,
        .rd_data, .rd_done, .cfg_err
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int seed, input int k);
        return DATA_W'(seed * 499 + k * 273 + 90);
    endfunction

    function automatic bit inwin(input int k, input int on, input int off);
        return (k >= on) && (k < off);
    endfunction

    // Called just after a negedge; returns just after a negedge, idle.
    task automatic run_access(input int con, input int coff, input int aon, input int aoff,
                              input int oon, input int ooff, input int acc, input int cyc,
                              input bit mux, input bit hold, input logic [ADDR_W-1:0] a,
                              input int seed, input bit scramble, input string rq);
        logic [DATA_W-1:0] old_d;
        logic [DATA_W-1:0] keep_e;
        t_cs_on = 4'(con);   t_cs_off = 5'(coff);
        t_adv_on = 4'(aon);  t_adv_off = 5'(aoff);
        t_oe_on = 4'(oon);   t_oe_off = 5'(ooff);
        t_capture = 5'(acc); t_cycle = 5'(cyc);
        mux_mode = mux; addr_hold = hold; req_addr = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        addr_m[HOLD-1:0] = a[HOLD-1:0];
        if (!hold) addr_m[ADDR_W-1:HOLD] = a[ADDR_W-1:HOLD];
        if (scramble) begin  // R13: these changes must not reach the running access
            t_cs_on = 4'd1; t_cs_off = 5'd1; t_oe_on = 4'd0; t_oe_off = 5'd2;
            t_capture = 5'd1; t_cycle = 5'd2; mux_mode = !mux;
        end
        old_d = data_m;
        for (int k = 0; k < cyc; k++) begin
            keep_e = (k >= acc) ? pat(seed, acc - 1) : old_d;
            chk({rq, " R2 ready"}, 32'(req_ready), 32'd0);
            chk({rq, " R3 cs_n"}, 32'(cs_n), 32'(!inwin(k, con, coff)));
            chk({rq, " R4 adv_n"}, 32'(adv_n), 32'(!inwin(k, aon, aoff)));
            chk({rq, " R5 oe_n"}, 32'(oe_n), 32'(!inwin(k, oon, ooff)));
            chk({rq, " R8 dir_in"}, 32'(dir_in), 32'(k >= oon));
            chk({rq, " R8 bus_oe"}, 32'(bus_oe), 32'(k < oon));
            chk({rq, " R6 rd_data"}, 32'(rd_data), 32'(keep_e));
            chk({rq, " R11 addr_out"}, 32'(addr_out), 32'(addr_m));
            chk({rq, " R7 done low"}, 32'(rd_done), 32'd0);
            if (k < oon) begin
                if (mux) chk({rq, " R9 mux addr"}, 32'(bus_out), 32'(addr_m[DATA_W-1:0]));
                else     chk({rq, " R10 keep"}, 32'(bus_out), 32'(keep_e));
            end
            bus_in = pat(seed, k);
            @(negedge clk);
        end
        data_m = pat(seed, acc - 1);
        chk({rq, " R7 done"}, 32'(rd_done), 32'd1);
        chk({rq, " R2 ready back"}, 32'(req_ready), 32'd1);
        chk({rq, " R3 cs idle"}, 32'(cs_n), 32'd1);
        chk({rq, " R6 captured"}, 32'(rd_data), 32'(data_m));
        chk({rq, " R10 idle bus"}, 32'(bus_out), 32'(data_m));
        chk({rq, " R8 idle drive"}, 32'(bus_oe), 32'd1);
        bus_in = 16'hDEAD;
        @(negedge clk);
        chk({rq, " R7 done one cycle"}, 32'(rd_done), 32'd0);
        chk({rq, " R6 hold"}, 32'(rd_data), 32'(data_m));
    endtask

    task automatic bad_req(input int coff, input int oon, input int ooff,
                           input int acc, input int cyc, input string rq);
        t_cs_on = 4'd0;  t_cs_off = 5'(coff);
        t_adv_on = 4'd0; t_adv_off = 5'd1;
        t_oe_on = 4'(oon); t_oe_off = 5'(ooff);
        t_capture = 5'(acc); t_cycle = 5'(cyc);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({rq, " R12 err"}, 32'(cfg_err), 32'd1);
        chk({rq, " R12 no start"}, 32'(req_ready), 32'd1);
        chk({rq, " R12 cs"}, 32'(cs_n), 32'd1);
        @(negedge clk);
        chk({rq, " R12 err pulse"}, 32'(cfg_err), 32'd0);
        chk({rq, " R12 idle"}, 32'(cs_n), 32'd1);
        chk({rq, " R12 data kept"}, 32'(rd_data), 32'(data_m));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 adv_n", 32'(adv_n), 32'd1);
        chk("R1 oe_n", 32'(oe_n), 32'd1);
        chk("R1 bus_oe", 32'(bus_oe), 32'd1);
        chk("R1 dir_in", 32'(dir_in), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rd_data", 32'(rd_data), 32'd0);
        chk("R1 bus_out", 32'(bus_out), 32'd0);
        chk("R1 addr_out", 32'(addr_out), 32'd0);
        chk("R1 done", 32'(rd_done), 32'd0);
        chk("R1 err", 32'(cfg_err), 32'd0);

        // R14 reference timing, multiplexed, inputs scrambled mid-access (R13)
        run_access(0, 10, 0, 1, 3, 10, 9, 11, 1'b1, 1'b0, 24'h5A3C71, 7, 1'b1, "R14 ref");
        run_access(0, 10, 0, 1, 3, 10, 9, 11, 1'b0, 1'b0, 24'h0F00E2, 8, 1'b0, "R14 ref nonmux");

        // R11 limited address
        run_access(0, 3, 0, 1, 1, 3, 2, 4, 1'b0, 1'b0, 24'hABCD12, 3, 1'b0, "R11 load");
        run_access(0, 3, 0, 1, 1, 3, 2, 4, 1'b1, 1'b1, 24'h123456, 4, 1'b0, "R11 hold");
        chk("R11 upper kept", 32'(addr_out), 32'h00ABCD56);

        // R12 rejected timings
        bad_req(2, 0, 2, 1, 0, "cycle zero");
        bad_req(2, 0, 2, 0, 3, "capture zero");
        bad_req(2, 0, 2, 4, 3, "capture late");
        bad_req(5, 0, 2, 2, 3, "cs off late");
        bad_req(3, 3, 2, 2, 3, "oe on after off");

        // Sweep over small timings
        for (int cyc = 1; cyc <= 6; cyc++) begin
            for (int acc = 1; acc <= cyc; acc++) begin
                for (int on = 0; on <= ((cyc < 3) ? cyc : 3); on++) begin
                    for (int off = on; off <= cyc; off++) begin
                        run_access((on > 0) ? on - 1 : 0, off, 0, on, on, off, acc, cyc,
                                   1'((cyc + acc + on) % 2), 1'b0,
                                   ADDR_W'(cyc * 4096 + acc * 257 + on * 16 + off),
                                   cyc * 100 + acc * 10 + on + off, 1'b0, "sweep");
                    end
                end
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule